// File: doc/BRIEF.md
# Static Memory Write Controller with Wait Freeze

This block runs one write access at a time on an asynchronous external static-memory bus. An internal master presents an address, a data word, byte enables and a timing set. The controller accepts them when idle and then steps a cycle counter. The counter places a chip-select strobe and a write-strobe inside the access, each with its own setup offset and pulse length, followed by a common hold tail. Address, data and byte selects stay constant for the whole access. A one-clock completion pulse marks the end.

The external device can stretch the access through an active-low wait pin. The pin is brought into the clock domain through a two-flop synchronizer. The synchronized value only counts when the freeze wait mode is selected and the counter sits in the last cycles of the controlling strobe pulse. The controlling strobe is the write strobe or the chip select, chosen by a configuration bit. While the wait is honoured, the counter and every bus pin hold still. When it is released, the access continues from the same count. A wait seen at any other point of the access is ignored.

Top module: `smc_write_ctrl`

## Requirements
- R1: After reset the controller is idle: `req_ready`=1, `done`=0, `mem_cs_n`=1, `mem_we_n`=1 and `mem_be_n` all ones.
- R2: A request is taken at a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the access ends. `req_valid` during an access starts nothing and changes no output.
- R3: Counting the first access cycle as count 0, `mem_cs_n` is 0 exactly for counts cs_setup to cs_setup+cs_pulse-1.
- R4: `mem_we_n` is 0 exactly for counts we_setup to we_setup+we_pulse-1.
- R5: An unfrozen access lasts max(cs_setup+cs_pulse, we_setup+we_pulse, 1)+hold cycles. For all of them, `mem_addr`, `mem_data` and `mem_be_n` (= ~byte enables) hold the values captured at acceptance. When idle, `mem_be_n` is all ones.
- R6: `done` is 1 for exactly one cycle, the first idle cycle after an access, with `req_ready`=1 in that cycle.
- R7: The wait pin passes through two flops. A low level present at the pin just before edge k is used in the decision at edge k+2.
- R8: With wait mode 2'b10 (freeze), a synchronized low wait while the count is inside the window keeps the count and every bus output unchanged for that cycle. After release the access continues from the same count, so its length grows by the number of frozen cycles.
- R9: The window is the last WIN_CYC counts of the write-strobe pulse when `cfg_we_ctrl`=1, or of the chip-select pulse when it is 0. If the pulse is not longer than WIN_CYC, the window is the whole pulse. A wait outside the window does not change the length.
- R10: Any wait mode other than 2'b10 ignores the wait pin entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Master requests a write |
| req_ready | output | 1 | Controller idle and able to accept |
| req_addr | input | ADDR_W | Write address |
| req_data | input | DATA_W | Write data |
| req_be | input | BE_W | Byte enables, active high |
| cfg_cs_setup | input | 6 | Chip-select setup in clocks |
| cfg_cs_pulse | input | 7 | Chip-select pulse in clocks |
| cfg_we_setup | input | 6 | Write-strobe setup in clocks |
| cfg_we_pulse | input | 7 | Write-strobe pulse in clocks |
| cfg_hold | input | 6 | Hold tail after the later strobe |
| cfg_we_ctrl | input | 1 | 1: write strobe defines the wait window; 0: chip select does |
| cfg_wait_mode | input | 2 | 2'b10 freeze; other values ignore wait |
| wait_n | input | 1 | External wait, active low, asynchronous |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_be_n | output | BE_W | Byte selects, active low |
| mem_addr | output | ADDR_W | Bus address |
| mem_data | output | DATA_W | Bus write data |
| done | output | 1 | One-cycle end-of-access pulse |

## Verification
The freeze decision and the window edge can fall in the same cycle. A wait that reaches the synchronizer output exactly when the count enters or leaves the window decides whether a cycle is held. The bench provokes this with single-cycle low pulses at the pin placed one clock apart around the window boundary. It judges each by the exact access length and by a cycle-accurate reference model compared on every clock. A second overlap is a stray request arriving while the access is frozen. It is judged by the absence of any further access after `done`.

// File: rtl/smc_pkg.sv
package smc_pkg;

    localparam int SETUP_W = 6;
    localparam int PULSE_W = 7;
    localparam int HOLD_W  = 6;
    localparam int CNT_W   = PULSE_W + 2;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        WAIT_OFF    = 2'b00,
        WAIT_RSV    = 2'b01,
        WAIT_FREEZE = 2'b10,
        WAIT_READY  = 2'b11
    } wait_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    typedef struct packed {
        logic [SETUP_W-1:0] cs_setup;
        logic [PULSE_W-1:0] cs_pulse;
        logic [SETUP_W-1:0] we_setup;
        logic [PULSE_W-1:0] we_pulse;
        logic [HOLD_W-1:0]  hold;
        logic               we_ctrl;
        wait_mode_e         wmode;
    } smc_timing_t;

    function automatic cnt_t strobe_end(input logic [SETUP_W-1:0] s,
                                        input logic [PULSE_W-1:0] p);
        return cnt_t'(s) + cnt_t'(p);
    endfunction

    function automatic cnt_t access_len(input smc_timing_t t);
        cnt_t a;
        cnt_t b;
        cnt_t e;
        a = strobe_end(t.cs_setup, t.cs_pulse);
        b = strobe_end(t.we_setup, t.we_pulse);
        e = (a > b) ? a : b;
        if (e == '0) e = cnt_t'(1);
        return e + cnt_t'(t.hold);
    endfunction

    function automatic logic in_window(input smc_timing_t t,
                                       input cnt_t c,
                                       input cnt_t win);
        cnt_t lo;
        cnt_t hi;
        cnt_t pl;
        cnt_t st;
        st = t.we_ctrl ? cnt_t'(t.we_setup) : cnt_t'(t.cs_setup);
        pl = t.we_ctrl ? cnt_t'(t.we_pulse) : cnt_t'(t.cs_pulse);
        hi = st + pl;
        lo = (pl > win) ? (hi - win) : st;
        return (c >= lo) && (c < hi);
    endfunction

endpackage

// File: rtl/smc_wait_sync.sv
module smc_wait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic sync_n
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= pin_n;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b1;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign sync_n = chain[STAGES-1];
endmodule

// File: rtl/smc_req_capture.sv
module smc_req_capture
    import smc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32,
    parameter int BE_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    input  logic [BE_W-1:0]   in_be,
    input  smc_timing_t       in_tim,
    output logic [ADDR_W-1:0] q_addr,
    output logic [DATA_W-1:0] q_data,
    output logic [BE_W-1:0]   q_be,
    output smc_timing_t       q_tim
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_addr <= '0;
            q_data <= '0;
            q_be   <= '0;
            q_tim  <= '0;
        end else if (take) begin
            q_addr <= in_addr;
            q_data <= in_data;
            q_be   <= in_be;
            q_tim  <= in_tim;
        end
    end
endmodule

// File: rtl/smc_cycle_fsm.sv
module smc_cycle_fsm
    import smc_pkg::*;
#(
    parameter int WIN_CYC = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  smc_timing_t tim,
    input  logic        wait_sync_n,
    output logic        take,
    output logic        busy,
    output logic        frozen,
    output cnt_t        count,
    output logic        done
);
    localparam cnt_t WIN = cnt_t'(WIN_CYC);

    run_state_e state;
    cnt_t       len;
    logic       last;
    logic       win_hit;

    assign busy = (state == ST_RUN);
    assign take = req_valid && !busy;

    always_comb begin
        len     = access_len(tim);
        win_hit = in_window(tim, count, WIN);
        last    = (count == len - cnt_t'(1));
        frozen  = busy && (tim.wmode == WAIT_FREEZE) && !wait_sync_n && win_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            count <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (take) begin
                    state <= ST_RUN;
                    count <= '0;
                end
            end else if (!frozen) begin
                if (last) begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end else begin
                    count <= count + cnt_t'(1);
                end
            end
        end
    end
endmodule

// File: rtl/smc_strobe_gen.sv
module smc_strobe_gen
    import smc_pkg::*;
#(
    parameter int BE_W = 4
) (
    input  logic        busy,
    input  cnt_t        count,
    input  smc_timing_t tim,
    input  logic [BE_W-1:0] be,
    output logic        cs_n,
    output logic        we_n,
    output logic [BE_W-1:0] be_n
);
    logic cs_on;
    logic we_on;

    always_comb begin
        cs_on = busy && (count >= cnt_t'(tim.cs_setup))
                     && (count <  strobe_end(tim.cs_setup, tim.cs_pulse));
        we_on = busy && (count >= cnt_t'(tim.we_setup))
                     && (count <  strobe_end(tim.we_setup, tim.we_pulse));
        cs_n  = !cs_on;
        we_n  = !we_on;
    end

    generate
        for (genvar b = 0; b < BE_W; b++) begin : g_lane
            assign be_n[b] = !(busy && be[b]);
        end
    endgenerate
endmodule

// File: rtl/smc_write_ctrl.sv
module smc_write_ctrl
    import smc_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int DATA_W      = 32,
    parameter int BE_W        = 4,
    parameter int SYNC_STAGES = 2,
    parameter int WIN_CYC     = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_data,
    input  logic [BE_W-1:0]    req_be,
    input  logic [SETUP_W-1:0] cfg_cs_setup,
    input  logic [PULSE_W-1:0] cfg_cs_pulse,
    input  logic [SETUP_W-1:0] cfg_we_setup,
    input  logic [PULSE_W-1:0] cfg_we_pulse,
    input  logic [HOLD_W-1:0]  cfg_hold,
    input  logic               cfg_we_ctrl,
    input  logic [1:0]         cfg_wait_mode,
    input  logic               wait_n,
    output logic               mem_cs_n,
    output logic               mem_we_n,
    output logic [BE_W-1:0]    mem_be_n,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_data,
    output logic               done
);
    smc_timing_t     tim_in;
    smc_timing_t     tim_q;
    logic [BE_W-1:0] be_q;
    logic            wait_sync_n;
    logic            take;
    logic            busy;
    logic            frozen;
    cnt_t            count;

    always_comb begin
        tim_in.cs_setup = cfg_cs_setup;
        tim_in.cs_pulse = cfg_cs_pulse;
        tim_in.we_setup = cfg_we_setup;
        tim_in.we_pulse = cfg_we_pulse;
        tim_in.hold     = cfg_hold;
        tim_in.we_ctrl  = cfg_we_ctrl;
        tim_in.wmode    = wait_mode_e'(cfg_wait_mode);
    end

    smc_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_n  (wait_n),
        .sync_n (wait_sync_n)
    );

    smc_req_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .in_addr (req_addr),
        .in_data (req_data),
        .in_be   (req_be),
        .in_tim  (tim_in),
        .q_addr  (mem_addr),
        .q_data  (mem_data),
        .q_be    (be_q),
        .q_tim   (tim_q)
    );

    smc_cycle_fsm #(.WIN_CYC(WIN_CYC)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .tim         (tim_q),
        .wait_sync_n (wait_sync_n),
        .take        (take),
        .busy        (busy),
        .frozen      (frozen),
        .count       (count),
        .done        (done)
    );

    smc_strobe_gen #(.BE_W(BE_W)) u_strb (
        .busy  (busy),
        .count (count),
        .tim   (tim_q),
        .be    (be_q),
        .cs_n  (mem_cs_n),
        .we_n  (mem_we_n),
        .be_n  (mem_be_n)
    );

    assign req_ready = !busy;
endmodule

// File: rtl/smc_write_chk.sv
module smc_write_chk #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32,
    parameter int BE_W   = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              mem_cs_n,
    input logic              mem_we_n,
    input logic [BE_W-1:0]   mem_be_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_data,
    input logic              done,
    input logic              frozen
);
    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> req_ready);

    // R5
    bus_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && $past(!req_ready)) |->
            ($stable(mem_addr) && $stable(mem_data) && $stable(mem_be_n)));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_cs_n && mem_we_n && (&mem_be_n)));

    // R8
    freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
        frozen |=> ($stable(mem_cs_n) && $stable(mem_we_n) && !req_ready && !done));
endmodule

bind smc_write_ctrl smc_write_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .mem_cs_n  (mem_cs_n),
    .mem_we_n  (mem_we_n),
    .mem_be_n  (mem_be_n),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data),
    .done      (done),
    .frozen    (frozen)
);

// File: tb/sim_smc_write_ctrl.sv
module sim_smc_write_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 24;
    localparam int DW = 32;
    localparam int BW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic [BW-1:0] req_be = '0;
    logic [5:0]    css = '0;
    logic [6:0]    csp = '0;
    logic [5:0]    wes = '0;
    logic [6:0]    wep = '0;
    logic [5:0]    hld = '0;
    logic          wctl = 1'b1;
    logic [1:0]    wmode = 2'b10;
    logic          wait_n = 1'b1;
    logic          mem_cs_n, mem_we_n, done;
    logic [BW-1:0] mem_be_n;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_data;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smc_write_ctrl #(.ADDR_W(AW), .DATA_W(DW), .BE_W(BW)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .req_be(req_be),
        .cfg_cs_setup(css), .cfg_cs_pulse(csp), .cfg_we_setup(wes),
        .cfg_we_pulse(wep), .cfg_hold(hld), .cfg_we_ctrl(wctl),
        .cfg_wait_mode(wmode), .wait_n(wait_n),
        .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_be_n(mem_be_n),
        .mem_addr(mem_addr), .mem_data(mem_data), .done(done)
    );

    // ---------------- behavioural reference ----------------
    int m_busy = 0, m_cnt = 0, m_done = 0;
    int l_css = 0, l_csp = 0, l_wes = 0, l_wep = 0, l_hld = 0, l_wc = 0, l_mode = 0;
    logic [AW-1:0] l_addr = '0;
    logic [DW-1:0] l_data = '0;
    logic [BW-1:0] l_be = '0;
    bit sq[$];

    function automatic int f_len(int a, int b, int c, int d, int h);
        int e;
        e = (a + b > c + d) ? a + b : c + d;
        if (e < 1) e = 1;
        return e + h;
    endfunction

    function automatic bit f_win(int cnt);
        int st, pl, hi, lo;
        st = l_wc ? l_wes : l_css;
        pl = l_wc ? l_wep : l_csp;
        hi = st + pl;
        lo = (pl > 2) ? hi - 2 : st;
        return (cnt >= lo) && (cnt < hi);
    endfunction

    initial begin sq.push_back(1'b1); sq.push_back(1'b1); end

    always @(posedge clk) begin
        bit s_out;
        bit frz;
        if (rst) begin
            m_busy = 0; m_cnt = 0; m_done = 0;
            l_addr = '0; l_data = '0; l_be = '0;
            l_css = 0; l_csp = 0; l_wes = 0; l_wep = 0; l_hld = 0; l_wc = 0; l_mode = 0;
            sq.delete(); sq.push_back(1'b1); sq.push_back(1'b1);
        end else begin
            s_out = sq[0];
            frz = (m_busy != 0) && (l_mode == 2) && !s_out && f_win(m_cnt);
            void'(sq.pop_front());
            sq.push_back(wait_n);
            if (m_busy == 0) begin
                m_done = 0;
                if (req_valid) begin
                    m_busy = 1; m_cnt = 0;
                    l_addr = req_addr; l_data = req_data; l_be = req_be;
                    l_css = css; l_csp = csp; l_wes = wes; l_wep = wep;
                    l_hld = hld; l_wc = wctl; l_mode = wmode;
                end
            end else if (frz) begin
                m_done = 0;
            end else if (m_cnt == f_len(l_css, l_csp, l_wes, l_wep, l_hld) - 1) begin
                m_busy = 0; m_done = 1;
            end else begin
                m_cnt = m_cnt + 1; m_done = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison, a quarter period after each rising edge
    always begin
        logic e_cs, e_we;
        logic [BW-1:0] e_be;
        @(posedge clk);
        #(CLK_PERIOD/4);
        if (!rst && !finished) begin
            e_cs = !(m_busy != 0 && m_cnt >= l_css && m_cnt < l_css + l_csp);
            e_we = !(m_busy != 0 && m_cnt >= l_wes && m_cnt < l_wes + l_wep);
            e_be = (m_busy != 0) ? ~l_be : '1;
            chk(req_ready == (m_busy == 0), "R2 ready", req_ready, m_busy == 0);
            chk(done == (m_done != 0), "R6 done", done, m_done);
            chk(mem_cs_n == e_cs, "R3 cs_n", mem_cs_n, e_cs);
            chk(mem_we_n == e_we, "R4 we_n", mem_we_n, e_we);
            chk(mem_be_n == e_be, "R5 be_n", mem_be_n, e_be);
            chk(mem_addr == l_addr, "R5 addr", mem_addr, l_addr);
            chk(mem_data == l_data, "R5 data", mem_data, l_data);
        end
    end

    // one access; the wait pin is low at negedges k in [ws, ws+wl)
    task automatic run_access(input int ws, input int wl, output int len);
        int k;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr = req_addr + 24'h111;
        req_data = req_data ^ 32'hA5C3_0F01 + 32'd7;
        req_be = req_be + 4'd3;
        @(negedge clk);
        req_valid = 1'b0;
        k = 0; len = 0;
        while (!req_ready && k < 2000) begin
            wait_n = (k >= ws && k < ws + wl) ? 1'b0 : 1'b1;
            len++; k++;
            @(negedge clk);
        end
        wait_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic set_cfg(input int a, b, c, d, h, wc, md);
        css = 6'(a); csp = 7'(b); wes = 6'(c); wep = 7'(d); hld = 6'(h);
        wctl = 1'(wc); wmode = 2'(md);
    endtask

    initial begin
        int len;
        int idle_ok;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
        chk(done == 1'b0, "R1 done", done, 0);
        chk(mem_cs_n && mem_we_n, "R1 strobes", {mem_cs_n, mem_we_n}, 3);
        chk(mem_be_n == '1, "R1 be_n", mem_be_n, 15);

        // basic: cs 1+7, we 2+5, hold 2 -> 10
        set_cfg(1, 7, 2, 5, 2, 1, 2);
        run_access(1000, 0, len);
        chk(len == 10, "R3 R4 R5 length", len, 10);

        // zero setup and hold
        set_cfg(0, 3, 0, 3, 0, 1, 2);
        run_access(1000, 0, len);
        chk(len == 3, "R5 zero setup length", len, 3);

        // R7 synchronizer delay: pin low at k lands on count k+2; window counts 5,6
        set_cfg(1, 7, 2, 5, 2, 1, 2);
        run_access(2, 1, len);
        chk(len == 10, "R7 pulse lands before window", len, 10);
        run_access(3, 1, len);
        chk(len == 11, "R7 R8 pulse lands on window start", len, 11);
        run_access(4, 1, len);
        chk(len == 11, "R8 pulse lands on window end", len, 11);
        run_access(5, 1, len);
        chk(len == 10, "R9 pulse lands after window", len, 10);

        // R8 long freeze resumes at same count
        run_access(3, 20, len);
        chk(len == 30, "R8 long freeze length", len, 30);

        // R9 waits outside window only
        run_access(0, 3, len);
        chk(len == 10, "R9 wait in setup ignored", len, 10);
        run_access(7, 3, len);
        chk(len == 10, "R9 wait in hold ignored", len, 10);

        // R9 chip-select controlled window: counts 6,7
        set_cfg(1, 7, 2, 5, 2, 0, 2);
        run_access(5, 1, len);
        chk(len == 11, "R9 cs window end", len, 11);
        run_access(3, 1, len);
        chk(len == 10, "R9 cs window excludes count 5", len, 10);

        // R9 short pulse: window is whole 1-cycle write pulse at count 2
        set_cfg(1, 7, 2, 1, 2, 1, 2);
        run_access(0, 1, len);
        chk(len == 11, "R9 short pulse window", len, 11);

        // R10 other mode ignores wait
        set_cfg(1, 7, 2, 5, 2, 1, 0);
        run_access(0, 40, len);
        chk(len == 10, "R10 mode 00 ignores wait", len, 10);
        set_cfg(1, 7, 2, 5, 2, 1, 3);
        run_access(0, 40, len);
        chk(len == 10, "R10 mode 11 ignores wait", len, 10);

        // R2 request during a frozen access starts nothing
        set_cfg(1, 7, 2, 5, 2, 1, 2);
        @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_n = 1'b0;
        repeat (8) @(negedge clk);
        req_valid = 1'b1;
        req_addr = 24'h00DEAD;
        @(negedge clk);
        req_valid = 1'b0;
        wait_n = 1'b1;
        while (!req_ready) @(negedge clk);
        idle_ok = 1;
        repeat (6) begin
            @(negedge clk);
            if (!req_ready || !mem_cs_n || mem_addr == 24'h00DEAD) idle_ok = 0;
        end
        chk(idle_ok == 1, "R2 stray request ignored", idle_ok, 1);

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule